// File: doc/BRIEF.md
# In-band loopback code detector

This block watches the received payload bit stream of a T1 line for the two repeating in-band loopback codes. The activate code repeats every five bits with a single one per period. The deactivate code repeats every three bits with a single one per period. The codes run straight through the frame structure, so the framing bits that the line inserts are skipped, and only payload bits take part in the search. Bits arrive one at a time, qualified by a valid strobe. A separate flag marks framing-bit positions.

For each code, a qualifying counter tracks how many consecutive payload bits fit that code. A payload bit fits a code of period P when it equals the payload bit P positions earlier and the last P payload bits, itself included, hold exactly one 1. After 1024 consecutive fitting bits, a sticky event flag for that code is set. The flag holds until the reader pulses a clear strobe. While the upstream framer reports that frame alignment is lost, the search history and both counters are held in reset.

Top module: `loopCodeDetect`

## Requirements
- R1: A payload bit fits the activate code when it equals the payload bit 5 positions earlier and the 5 most recent payload bits, itself included, contain exactly one 1. `codeOnEvt` goes to 1 on the clock edge that takes in the 1024th consecutive fitting payload bit. The activate and deactivate flags never rise in the same cycle.
- R2: The deactivate code follows the same rule as R1 with a period of 3, and sets `codeOffEvt`.
- R3: A bit is payload only when `bitValid`=1 and `framingSlot`=0. A bit with `framingSlot`=1, or a cycle with `bitValid`=0, is left out of the history and the counters and cannot set a flag.
- R4: A stream of all zeros or all ones never sets either flag.
- R5: Once set, an event flag stays at 1 until `readClr` is 1 at a clock edge.
- R6: `readClr`=1 at a clock edge clears both flags. If a detection happens on that same edge, the detecting flag stays 1.
- R7: A payload bit that does not fit a code restarts that code's count of consecutive fitting bits from zero.
- R8: While `alignValid`=0, the payload history and both counts are cleared and no flag can be set. Flags that are already set keep their value.
- R9: Asynchronous active-low reset `rstN` clears both flags, the history and the counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxBit | input | 1 | Received serial bit |
| bitValid | input | 1 | rxBit carries a bit this cycle |
| framingSlot | input | 1 | The current bit sits in a framing position |
| alignValid | input | 1 | The upstream framer holds frame alignment |
| readClr | input | 1 | Read strobe that clears both event flags |
| codeOnEvt | output | 1 | Sticky flag: loopback activate code detected |
| codeOffEvt | output | 1 | Sticky flag: loopback deactivate code detected |

## Verification
The assertions assume that all inputs are known after reset. They also assume that a framing-position bit never counts toward a code, whatever its value. The stimulus places a framing bit with a random value every 193 bits and inserts random idle cycles with `bitValid` low. It drops `alignValid` only for a few cycles between or within streams. The clear strobe is either a single pulse on an idle cycle or held high across a whole stream, so that a detection falls in a cycle where the clear is also asserted.

// File: rtl/loopCodePkg.sv
package loopCodePkg;
  localparam int ON_PERIOD  = 5;
  localparam int OFF_PERIOD = 3;
  localparam int NUM_CODES  = 2;
  localparam int QUAL_LEN   = 1024;

  // strobes from the control to the datapath
  typedef struct packed {
    logic shiftEn;  // a payload bit is presented this cycle
    logic flush;    // clear history (alignment lost)
  } ctrlStrobe_t;
endpackage

// File: rtl/loopCodeDatapath.sv
module loopCodeDatapath
  import loopCodePkg::*;
#(
  parameter int ON_P  = ON_PERIOD,
  parameter int OFF_P = OFF_PERIOD
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxBit,
  input  ctrlStrobe_t strobe,
  output logic [1:0]  codeMatch
);
  localparam int HIST_W = (ON_P > OFF_P) ? ON_P : OFF_P;
  localparam int FILL_W = $clog2(HIST_W + 1);

  // hist[k-1] is the payload bit k positions before the current one
  logic [HIST_W-1:0] hist;
  logic [FILL_W-1:0] fill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist <= '0;
      fill <= '0;
    end else if (strobe.flush) begin
      hist <= '0;
      fill <= '0;
    end else if (strobe.shiftEn) begin
      hist <= {hist[HIST_W-2:0], rxBit};
      if (fill != FILL_W'(HIST_W)) fill <= fill + 1'b1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_code
    localparam int P = (g == 0) ? ON_P : OFF_P;
    logic [P-1:0] window;
    logic         oneHot;
    always_comb begin
      window       = {hist[P-2:0], rxBit};
      oneHot       = ($countones(window) == 1);
      codeMatch[g] = (fill >= FILL_W'(P)) && (rxBit == hist[P-1]) && oneHot;
    end
  end
endmodule

// File: rtl/loopCodeControl.sv
module loopCodeControl
  import loopCodePkg::*;
#(
  parameter int QUAL  = QUAL_LEN,
  parameter int CODES = NUM_CODES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitValid,
  input  logic             framingSlot,
  input  logic             alignValid,
  input  logic             readClr,
  input  logic [CODES-1:0] codeMatch,
  output ctrlStrobe_t      strobe,
  output logic [CODES-1:0] codeEvt
);
  localparam int CNT_W = $clog2(QUAL + 1);

  always_comb begin
    strobe.shiftEn = alignValid & bitValid & ~framingSlot;
    strobe.flush   = ~alignValid;
  end

  for (genvar g = 0; g < CODES; g++) begin : g_qual
    logic [CNT_W-1:0] runCnt;
    logic             detect;

    assign detect = strobe.shiftEn & codeMatch[g] & (runCnt == CNT_W'(QUAL - 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (strobe.flush) begin
        runCnt <= '0;
      end else if (strobe.shiftEn) begin
        if (!codeMatch[g])                   runCnt <= '0;
        else if (runCnt != CNT_W'(QUAL))     runCnt <= runCnt + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        codeEvt[g] <= 1'b0;
      else if (detect)  codeEvt[g] <= 1'b1;
      else if (readClr) codeEvt[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/loopCodeDetect.sv
module loopCodeDetect
  import loopCodePkg::*;
#(
  parameter int ON_P  = ON_PERIOD,
  parameter int OFF_P = OFF_PERIOD,
  parameter int QUAL  = QUAL_LEN
) (
  input  logic clk,
  input  logic rstN,
  input  logic rxBit,
  input  logic bitValid,
  input  logic framingSlot,
  input  logic alignValid,
  input  logic readClr,
  output logic codeOnEvt,
  output logic codeOffEvt
);
  ctrlStrobe_t strobe;
  logic [1:0]  codeMatch;
  logic [1:0]  codeEvt;

  loopCodeControl #(.QUAL(QUAL), .CODES(2)) ctrl_i (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .framingSlot(framingSlot),
    .alignValid(alignValid), .readClr(readClr), .codeMatch(codeMatch),
    .strobe(strobe), .codeEvt(codeEvt)
  );

  loopCodeDatapath #(.ON_P(ON_P), .OFF_P(OFF_P)) dp_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .strobe(strobe), .codeMatch(codeMatch)
  );

  assign codeOnEvt  = codeEvt[0];
  assign codeOffEvt = codeEvt[1];
endmodule

// File: rtl/loopCodeChecker.sv
module loopCodeChecker (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic framingSlot,
  input logic alignValid,
  input logic readClr,
  input logic codeOnEvt,
  input logic codeOffEvt
);
  AST_ON_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    codeOnEvt && !readClr |=> codeOnEvt); // R5
  AST_OFF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    codeOffEvt && !readClr |=> codeOffEvt); // R5
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    readClr && !(bitValid && alignValid && !framingSlot) |=> !codeOnEvt && !codeOffEvt); // R6
  AST_SKIP_FRAMING: assert property (@(posedge clk) disable iff (!rstN)
    framingSlot && !codeOnEvt && !codeOffEvt |=> !codeOnEvt && !codeOffEvt); // R3
  AST_HOLD_UNALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    !alignValid && !codeOnEvt && !codeOffEvt |=> !codeOnEvt && !codeOffEvt); // R8
  AST_EXCLUSIVE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(codeOnEvt) |-> !$rose(codeOffEvt)); // R1
endmodule

bind loopCodeDetect loopCodeChecker chk_i (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .framingSlot(framingSlot),
  .alignValid(alignValid), .readClr(readClr),
  .codeOnEvt(codeOnEvt), .codeOffEvt(codeOffEvt)
);

// File: tb/loopCodeDetect_tb.sv
module loopCodeDetect_tb_top;
  localparam int QUAL = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, rxBit = 1'b0, bitValid = 1'b0, framingSlot = 1'b0;
  logic alignValid = 1'b0, readClr = 1'b0;
  logic codeOnEvt, codeOffEvt;

  loopCodeDetect dut_i (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .bitValid(bitValid),
    .framingSlot(framingSlot), .alignValid(alignValid), .readClr(readClr),
    .codeOnEvt(codeOnEvt), .codeOffEvt(codeOffEvt)
  );

  int checks = 0, fails = 0;
  string phaseTag = "R9";
  bit finished = 1'b0;
  bit sawOnHigh = 1'b0;
  int framePos = 0;
  int patIdx = 0;

  // ---------------- behavioural reference model ----------------
  bit histQ[$];
  int onRun = 0, offRun = 0;
  bit mOn = 1'b0, mOff = 1'b0;

  function automatic bit periodicHit(int p);
    int n;
    int ones;
    n = histQ.size();
    ones = 0;
    if (n < p + 1) return 1'b0;
    if (histQ[n-1] != histQ[n-1-p]) return 1'b0;
    for (int i = 0; i < p; i++) ones += int'(histQ[n-1-i]);
    return ones == 1;
  endfunction

  always @(posedge clk) begin
    bit dOn, dOff;
    dOn = 1'b0;
    dOff = 1'b0;
    if (!rstN) begin
      histQ.delete(); onRun = 0; offRun = 0; mOn = 1'b0; mOff = 1'b0;
    end else begin
      if (!alignValid) begin
        histQ.delete(); onRun = 0; offRun = 0;
      end else if (bitValid && !framingSlot) begin
        histQ.push_back(rxBit);
        if (histQ.size() > 8) void'(histQ.pop_front());
        if (periodicHit(5)) begin onRun++; if (onRun == QUAL) dOn = 1'b1; end
        else onRun = 0;
        if (periodicHit(3)) begin offRun++; if (offRun == QUAL) dOff = 1'b1; end
        else offRun = 0;
      end
      mOn  = dOn  || (mOn  && !readClr);
      mOff = dOff || (mOff && !readClr);
    end
  end

  task automatic check(string tag, logic act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare the design against the model on every clock
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(phaseTag, codeOnEvt, mOn, "codeOnEvt vs model");
      check(phaseTag, codeOffEvt, mOff, "codeOffEvt vs model");
      if (codeOnEvt) sawOnHigh = 1'b1;
    end
  end

  function automatic bit patBit(int kind, int i);
    case (kind)
      0:       return (i % 5) == 4;
      1:       return (i % 3) == 2;
      2:       return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  task automatic sendPayload(int kind, int count, int errAt, bit clr);
    int idx;
    idx = 0;
    while (idx < count) begin
      @(negedge clk);
      readClr = clr;
      if ($urandom_range(0, 7) == 0) begin
        bitValid = 1'b0; framingSlot = 1'b0; rxBit = 1'($urandom_range(0, 1));
      end else begin
        bitValid = 1'b1;
        if (framePos == 0) begin
          framingSlot = 1'b1; rxBit = 1'($urandom_range(0, 1));
        end else begin
          framingSlot = 1'b0;
          rxBit = patBit(kind, patIdx) ^ (idx == errAt);
          patIdx++; idx++;
        end
        framePos = (framePos == 192) ? 0 : framePos + 1;
      end
    end
    @(negedge clk);
    bitValid = 1'b0; framingSlot = 1'b0; readClr = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); readClr = 1'b1;
    @(negedge clk); readClr = 1'b0;
  endtask

  task automatic dropAlign(int n);
    @(negedge clk); alignValid = 1'b0;
    repeat (n) @(negedge clk);
    alignValid = 1'b1;
  endtask

  task automatic finishRun();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9", codeOnEvt, 1'b0, "reset activate flag");
    check("R9", codeOffEvt, 1'b0, "reset deactivate flag");
    rstN = 1'b1; alignValid = 1'b1;

    phaseTag = "R1";
    sendPayload(0, 1100, -1, 1'b0);
    check("R1", codeOnEvt, 1'b1, "activate code detected");
    check("R3", codeOnEvt, 1'b1, "framing bits skipped while matching");
    check("R2", codeOffEvt, 1'b0, "no deactivate on activate code");
    phaseTag = "R5";
    repeat (6) @(negedge clk);
    check("R5", codeOnEvt, 1'b1, "flag held without clear");
    pulseClear();
    @(negedge clk);
    check("R6", codeOnEvt, 1'b0, "clear strobe drops flag");

    phaseTag = "R2";
    sendPayload(1, 1100, -1, 1'b0);
    check("R2", codeOffEvt, 1'b1, "deactivate code detected");
    check("R1", codeOnEvt, 1'b0, "no activate on deactivate code");
    pulseClear();

    phaseTag = "R4";
    sendPayload(2, 1200, -1, 1'b0);
    check("R4", codeOnEvt, 1'b0, "all zeros activate");
    check("R4", codeOffEvt, 1'b0, "all zeros deactivate");
    sendPayload(3, 1200, -1, 1'b0);
    check("R4", codeOnEvt, 1'b0, "all ones activate");
    check("R4", codeOffEvt, 1'b0, "all ones deactivate");

    phaseTag = "R7";
    sendPayload(0, 1100, 600, 1'b0);
    check("R7", codeOnEvt, 1'b0, "error bit restarts count");
    sendPayload(0, 1100, -1, 1'b0);
    check("R7", codeOnEvt, 1'b1, "detected after restart");
    pulseClear();

    phaseTag = "R8";
    sendPayload(0, 700, -1, 1'b0);
    dropAlign(4);
    sendPayload(0, 700, -1, 1'b0);
    check("R8", codeOnEvt, 1'b0, "alignment loss restarts search");
    sendPayload(0, 400, -1, 1'b0);
    check("R8", codeOnEvt, 1'b1, "detected after realignment");
    @(negedge clk); alignValid = 1'b0;
    repeat (5) @(negedge clk);
    check("R8", codeOnEvt, 1'b1, "flag kept while unaligned");
    alignValid = 1'b1;
    pulseClear();

    phaseTag = "R6";
    dropAlign(2);
    sawOnHigh = 1'b0;
    sendPayload(0, 1100, -1, 1'b1);
    check("R6", sawOnHigh, 1'b1, "detection wins over coincident clear");
    @(negedge clk);
    check("R6", codeOnEvt, 1'b0, "held clear empties flag afterwards");

    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule